// File: doc/BRIEF.md
# Codec Register Mailbox

This block gives host software a mailbox for reading and writing the 16-bit control registers of an audio codec. Software sees two 32-bit words: a command/status word for writes and one for reads. Each word holds a register address in its low byte, a busy flag at bit 15 and a 16-bit data field in its upper half. A host store to a word with bit 15 set becomes exactly one transaction on a codec-side valid/ready handshake. Software then polls the same word until bit 15 drops.

Read data lands in bits 31:16 of the read word. A build parameter can instead merge both words into a single status word. That word always shows the most recent transaction, so read results appear at the write word's address. Serial link framing and codec reset sequencing are not part of this block.

Top module: `codec_mailbox`

## Requirements
- R1: A host store to the write word (`host_port` = 0) with bit 15 set starts one codec write. `cdc_write` = 1, the address comes from bits 7:0 and the data from bits 31:16. On completion the write word reads {data, 0, 7'b0, address}.
- R2: A host store to the read word (`host_port` = 1) with bit 15 set starts one codec read with `cdc_write` = 0. When it completes, bits 31:16 of the read word hold the codec's returned data and bits 7:0 hold the address.
- R3: Bit 15 of the word that issued the command is 1 from the cycle after the command is accepted until the handshake cycle. It reads 0 in the cycle after the cycle in which `cdc_valid` and `cdc_ready` are both high. With a codec that answers after L wait cycles, bit 15 is seen set for exactly L+1 cycles.
- R4: A command stored while a transaction is pending is ignored. The pending request's address and data do not change, the ignored command never reaches the codec, and the status word keeps the first command's fields.
- R5: Bit 0 of the address is forced to 0, both on `cdc_addr` and in the status word.
- R6: After reset both words read 0 and `cdc_valid` is 0.
- R7: While `cdc_valid` is high and `cdc_ready` is low, `cdc_valid`, `cdc_write`, `cdc_addr` and `cdc_wdata` hold their values.
- R8: A host store with bit 15 clear starts no transaction and leaves both words unchanged.
- R9: With `SHARED_RESULT` = 1, both words show the same value: {last data, busy, 7'b0, last address}. The last data is the read result after a read and the write data after a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_we | input | 1 | Host store strobe, one cycle |
| host_port | input | 1 | 0 selects the write word, 1 the read word |
| host_wdata | input | 32 | Host store value |
| wport_word | output | 32 | Write command/status word |
| rport_word | output | 32 | Read command/status word |
| cdc_valid | output | 1 | Codec request valid |
| cdc_write | output | 1 | 1 for a write request, 0 for a read |
| cdc_addr | output | 8 | Codec register address, always even |
| cdc_wdata | output | 16 | Codec write data |
| cdc_ready | input | 1 | Codec acknowledge; completes the request when high with `cdc_valid` |
| cdc_rdata | input | 16 | Codec read data, valid in the acknowledge cycle |

## Verification
The bench builds two copies. The first uses separate words (`SHARED_RESULT` = 0) and talks to a codec model that waits three cycles before acknowledging. That makes a pending window long enough to store a second command into it, and to check that the request stays stable across wait cycles. The second copy uses the merged word (`SHARED_RESULT` = 1) with a codec that acknowledges at once. It covers the shortest busy window and shows that a read result replaces the previous write's data in the shared word.

// File: rtl/cmbx_pkg.sv
// Shared constants and types for the codec register mailbox.
// Assumes the fixed 32-bit command word layout: data in the upper half,
// busy/command flag at bit 15, register address in the low byte.
package cmbx_pkg;
    localparam int WORD_W   = 32;
    localparam int DATA_W   = 16;
    localparam int ADDR_W   = 8;
    localparam int FLAG_BIT = 15;
    localparam int DATA_LSB = WORD_W - DATA_W;
    localparam int GAP_W    = FLAG_BIT - ADDR_W;

    typedef struct packed {
        logic              is_read;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } cmd_t;
endpackage

// File: rtl/cmbx_decode.sv
// Decodes a host store into a mailbox command.
// Assumes host_we is a single-cycle strobe. A store is accepted only when
// its flag bit is set and no transaction is pending. Address bit 0 is dropped.
module cmbx_decode
    import cmbx_pkg::*;
(
    input  logic              host_we,
    input  logic              host_port,
    input  logic [WORD_W-1:0] host_wdata,
    input  logic              engine_busy,
    output logic              cmd_fire,
    output cmd_t              cmd
);
    // Split the host word into fields and qualify acceptance.
    always_comb begin
        cmd.is_read = host_port;
        cmd.addr    = {host_wdata[ADDR_W-1:1], 1'b0};
        cmd.data    = host_wdata[DATA_LSB +: DATA_W];
        cmd_fire    = host_we & host_wdata[FLAG_BIT] & ~engine_busy;
    end
endmodule

// File: rtl/cmbx_engine.sv
// Holds one codec request on a valid/ready handshake.
// Assumes the codec drives cdc_rdata in the same cycle as cdc_ready.
// The request drops at the acknowledging edge.
module cmbx_engine
    import cmbx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_fire,
    input  cmd_t              cmd,
    input  logic              cdc_ready,
    input  logic [DATA_W-1:0] cdc_rdata,
    output logic              cdc_valid,
    output logic              cdc_write,
    output logic [ADDR_W-1:0] cdc_addr,
    output logic [DATA_W-1:0] cdc_wdata,
    output logic              done,
    output logic [DATA_W-1:0] done_rdata
);
    cmd_t pend_q;
    logic valid_q;

    // Launch on an accepted command, retire on the handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            pend_q  <= '0;
        end else if (valid_q && cdc_ready) begin
            valid_q <= 1'b0;
        end else if (cmd_fire) begin
            valid_q <= 1'b1;
            pend_q  <= cmd;
        end
    end

    // Drive the codec request and the completion pulse.
    always_comb begin
        cdc_valid  = valid_q;
        cdc_write  = ~pend_q.is_read;
        cdc_addr   = pend_q.addr;
        cdc_wdata  = pend_q.data;
        done       = valid_q & cdc_ready;
        done_rdata = cdc_rdata;
    end

    // R7: request held while the codec stalls
    p_hold_request_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cdc_valid && !cdc_ready) |=> (cdc_valid && $stable(cdc_addr)
                                       && $stable(cdc_wdata) && $stable(cdc_write)));
    // R3: request released after the acknowledge
    p_release_after_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cdc_valid && cdc_ready) |=> !cdc_valid);
    // R8: no request appears without an accepted command
    p_no_spurious_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cdc_valid && !cmd_fire) |=> !cdc_valid);
    // R5: only even addresses reach the codec
    p_even_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cdc_valid |-> !cdc_addr[0]);
endmodule

// File: rtl/cmbx_status.sv
// Keeps the host-visible command/status words.
// Assumes busy mirrors the pending request. SHARED_RESULT selects
// separate write/read words or one merged word shown on both outputs.
module cmbx_status
    import cmbx_pkg::*;
#(
    parameter bit SHARED_RESULT = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_fire,
    input  cmd_t              cmd,
    input  logic              busy,
    input  logic              done,
    input  logic [DATA_W-1:0] done_rdata,
    output logic [WORD_W-1:0] wport_word,
    output logic [WORD_W-1:0] rport_word
);
    logic [ADDR_W-1:0] waddr_q, raddr_q;
    logic [DATA_W-1:0] wdata_q, rdata_q;
    logic              last_rd_q;

    // Record command fields at acceptance and read data at completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            waddr_q   <= '0;
            raddr_q   <= '0;
            wdata_q   <= '0;
            rdata_q   <= '0;
            last_rd_q <= 1'b0;
        end else begin
            if (cmd_fire) begin
                last_rd_q <= cmd.is_read;
                if (cmd.is_read) begin
                    raddr_q <= cmd.addr;
                end else begin
                    waddr_q <= cmd.addr;
                    wdata_q <= cmd.data;
                end
            end
            if (done && last_rd_q) begin
                rdata_q <= done_rdata;
            end
        end
    end

    generate
        if (SHARED_RESULT) begin : g_shared
            logic [DATA_W-1:0] last_data;
            logic [ADDR_W-1:0] last_addr;
            // Merge the most recent transaction into one word.
            always_comb begin
                last_data  = last_rd_q ? rdata_q : wdata_q;
                last_addr  = last_rd_q ? raddr_q : waddr_q;
                wport_word = {last_data, busy, {GAP_W{1'b0}}, last_addr};
                rport_word = wport_word;
            end
        end else begin : g_split
            // Separate words, each flagging only its own pending kind.
            always_comb begin
                wport_word = {wdata_q, busy & ~last_rd_q, {GAP_W{1'b0}}, waddr_q};
                rport_word = {rdata_q, busy &  last_rd_q, {GAP_W{1'b0}}, raddr_q};
            end
            // R3: at most one word reports busy
            p_one_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
                !(wport_word[FLAG_BIT] && rport_word[FLAG_BIT]));
        end
    endgenerate

    // R2: read data changes only on a completion
    p_rdata_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> $stable(rdata_q));
    // R4: write fields frozen while a transaction is pending
    p_fields_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(wdata_q) && $stable(waddr_q)));
endmodule

// File: rtl/codec_mailbox.sv
// Codec register mailbox top level.
// Assumes one host store per cycle at most and a codec that eventually
// acknowledges. Carries one transaction at a time.
module codec_mailbox
    import cmbx_pkg::*;
#(
    parameter bit SHARED_RESULT = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic              host_port,
    input  logic [WORD_W-1:0] host_wdata,
    output logic [WORD_W-1:0] wport_word,
    output logic [WORD_W-1:0] rport_word,
    output logic              cdc_valid,
    output logic              cdc_write,
    output logic [ADDR_W-1:0] cdc_addr,
    output logic [DATA_W-1:0] cdc_wdata,
    input  logic              cdc_ready,
    input  logic [DATA_W-1:0] cdc_rdata
);
    logic              cmd_fire;
    cmd_t              cmd;
    logic              done;
    logic [DATA_W-1:0] done_rdata;

    cmbx_decode u_decode (
        .host_we    (host_we),
        .host_port  (host_port),
        .host_wdata (host_wdata),
        .engine_busy(cdc_valid),
        .cmd_fire   (cmd_fire),
        .cmd        (cmd)
    );

    cmbx_engine u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_fire  (cmd_fire),
        .cmd       (cmd),
        .cdc_ready (cdc_ready),
        .cdc_rdata (cdc_rdata),
        .cdc_valid (cdc_valid),
        .cdc_write (cdc_write),
        .cdc_addr  (cdc_addr),
        .cdc_wdata (cdc_wdata),
        .done      (done),
        .done_rdata(done_rdata)
    );

    cmbx_status #(.SHARED_RESULT(SHARED_RESULT)) u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_fire  (cmd_fire),
        .cmd       (cmd),
        .busy      (cdc_valid),
        .done      (done),
        .done_rdata(done_rdata),
        .wport_word(wport_word),
        .rport_word(rport_word)
    );

    // R6: no request in the cycle after reset
    p_reset_idle_r6: assert property (@(posedge clk)
        !rst_n |=> !cdc_valid);
endmodule

// File: tb/codec_mailbox_test.sv
`timescale 1ns/1ps

// Behavioural codec register file: acknowledges after LAT wait cycles.
module cmbx_codec_model #(
    parameter int LAT = 0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        valid,
    input  logic        write,
    input  logic [7:0]  addr,
    input  logic [15:0] wdata,
    output logic        ready,
    output logic [15:0] rdata
);
    logic [15:0] mem [128];
    int cnt;

    assign ready = valid && (cnt == LAT);
    assign rdata = mem[addr[7:1]];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= 0;
            for (int i = 0; i < 128; i++) mem[i] <= '0;
        end else begin
            if (valid && ready) cnt <= 0;
            else if (valid)     cnt <= cnt + 1;
            if (valid && ready && write) mem[addr[7:1]] <= wdata;
        end
    end
endmodule

module codec_mailbox_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic        we0 = 0, port0 = 0, we1 = 0, port1 = 0;
    logic [31:0] wd0 = '0, wd1 = '0;
    logic [31:0] wword0, rword0, wword1, rword1;
    logic        v0, w0, rdy0, v1, w1, rdy1;
    logic [7:0]  a0, a1;
    logic [15:0] d0, d1, rd0, rd1;

    int checks = 0;
    int fails  = 0;
    bit ended  = 0;

    codec_mailbox #(.SHARED_RESULT(1'b0)) uut (
        .clk(clk), .rst_n(rst_n), .host_we(we0), .host_port(port0), .host_wdata(wd0),
        .wport_word(wword0), .rport_word(rword0), .cdc_valid(v0), .cdc_write(w0),
        .cdc_addr(a0), .cdc_wdata(d0), .cdc_ready(rdy0), .cdc_rdata(rd0));
    cmbx_codec_model #(.LAT(3)) cm0 (
        .clk(clk), .rst_n(rst_n), .valid(v0), .write(w0), .addr(a0), .wdata(d0),
        .ready(rdy0), .rdata(rd0));

    codec_mailbox #(.SHARED_RESULT(1'b1)) uut_shared (
        .clk(clk), .rst_n(rst_n), .host_we(we1), .host_port(port1), .host_wdata(wd1),
        .wport_word(wword1), .rport_word(rword1), .cdc_valid(v1), .cdc_write(w1),
        .cdc_addr(a1), .cdc_wdata(d1), .cdc_ready(rdy1), .cdc_rdata(rd1));
    cmbx_codec_model #(.LAT(0)) cm1 (
        .clk(clk), .rst_n(rst_n), .valid(v1), .write(w1), .addr(a1), .wdata(d1),
        .ready(rdy1), .rdata(rd1));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Store one host word; returns at the negedge after the accepting edge.
    task automatic issue(input bit which, input bit port, input logic [31:0] w);
        @(negedge clk);
        if (which) begin we1 = 1; port1 = port; wd1 = w; end
        else       begin we0 = 1; port0 = port; wd0 = w; end
        @(negedge clk);
        we0 = 0; we1 = 0;
    endtask

    // Poll the busy flag of the given word, counting cycles seen set.
    task automatic wait_idle(input bit which, input bit port, output int polls);
        polls = 0;
        while (polls < 100) begin
            logic [31:0] word;
            word = which ? wword1 : (port ? rword0 : wword0);
            if (!word[15]) break;
            polls++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        chk("R6 wport", wword0, 32'h0);
        chk("R6 rport", rword0, 32'h0);
        chk("R6 valid", {31'h0, v0}, 32'h0);
        chk("R6 shared word", wword1, 32'h0);
    endtask

    task automatic t_write();
        int n;
        issue(0, 0, {16'hBEEF, 1'b1, 7'h0, 8'h26});
        chk("R1 valid", {31'h0, v0}, 32'h1);
        chk("R1 write kind", {31'h0, w0}, 32'h1);
        chk("R1 addr", {24'h0, a0}, 32'h26);
        chk("R1 data", {16'h0, d0}, 32'hBEEF);
        wait_idle(0, 0, n);
        chk("R3 busy cycles L=3", n, 4);
        chk("R1 codec stored", {16'h0, cm0.mem[8'h26 >> 1]}, 32'hBEEF);
        chk("R1 word after", wword0, 32'hBEEF_0026);
    endtask

    task automatic t_odd_addr();
        int n;
        issue(0, 0, {16'h1234, 1'b1, 7'h0, 8'h31});
        chk("R5 codec addr even", {24'h0, a0}, 32'h30);
        wait_idle(0, 0, n);
        chk("R5 codec stored", {16'h0, cm0.mem[8'h30 >> 1]}, 32'h1234);
        chk("R5 word addr", wword0, 32'h1234_0030);
    endtask

    task automatic t_read();
        int n;
        issue(0, 1, {16'h0, 1'b1, 7'h0, 8'h26});
        chk("R2 read kind", {31'h0, w0}, 32'h0);
        chk("R3 read busy set", {31'h0, rword0[15]}, 32'h1);
        chk("R3 write word idle", {31'h0, wword0[15]}, 32'h0);
        wait_idle(0, 1, n);
        chk("R3 read busy cycles", n, 4);
        chk("R2 read result", rword0, 32'hBEEF_0026);
    endtask

    task automatic t_busy_ignore();
        int n;
        issue(0, 0, {16'hAAAA, 1'b1, 7'h0, 8'h40});
        issue(0, 0, {16'h5555, 1'b1, 7'h0, 8'h42});
        chk("R7 valid held", {31'h0, v0}, 32'h1);
        chk("R4 addr kept", {24'h0, a0}, 32'h40);
        chk("R4 data kept", {16'h0, d0}, 32'hAAAA);
        issue(0, 1, {16'h0, 1'b1, 7'h0, 8'h42});
        chk("R7 kind held", {31'h0, w0}, 32'h1);
        wait_idle(0, 0, n);
        repeat (3) @(negedge clk);
        chk("R4 first stored", {16'h0, cm0.mem[8'h40 >> 1]}, 32'hAAAA);
        chk("R4 second dropped", {16'h0, cm0.mem[8'h42 >> 1]}, 32'h0);
        chk("R4 word kept", wword0, 32'hAAAA_0040);
        chk("R4 read word untouched", rword0, 32'hBEEF_0026);
    endtask

    task automatic t_flag_clear();
        issue(0, 0, {16'h7E7E, 1'b0, 7'h0, 8'h50});
        chk("R8 no request", {31'h0, v0}, 32'h0);
        chk("R8 wport unchanged", wword0, 32'hAAAA_0040);
        issue(0, 1, {16'h0, 1'b0, 7'h0, 8'h50});
        chk("R8 no read request", {31'h0, v0}, 32'h0);
        chk("R8 rport unchanged", rword0, 32'hBEEF_0026);
    endtask

    task automatic t_shared();
        int n;
        issue(1, 0, {16'h0F0F, 1'b1, 7'h0, 8'h10});
        chk("R9 both busy", {30'h0, wword1[15], rword1[15]}, 32'h3);
        wait_idle(1, 0, n);
        chk("R3 busy cycles L=0", n, 1);
        issue(1, 0, {16'h7777, 1'b1, 7'h0, 8'h12});
        wait_idle(1, 0, n);
        chk("R9 after write", wword1, 32'h7777_0012);
        issue(1, 1, {16'h0, 1'b1, 7'h0, 8'h10});
        wait_idle(1, 0, n);
        chk("R9 read in shared word", wword1, 32'h0F0F_0010);
        chk("R9 words equal", rword1, 32'h0F0F_0010);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_write();
        t_odd_addr();
        t_read();
        t_busy_ignore();
        t_flag_clear();
        t_shared();
        ended = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!ended) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule